// File: doc/BRIEF.md
# Clock Synthesis Parameter Search Engine

This block takes an input clock frequency and a wanted output frequency, both in kHz, and searches for the three divider settings of a phase-locked clock synthesizer. These are a pre-divider D, a feedback multiplier M and an output divider DOUT. The synthesized frequency is fin*M/(D*DOUT), and the engine picks the setting whose result lies closest to the target. The phase-detector frequency fin/D and the oscillator frequency fin*M/D must stay inside limits that are set as parameters. The defaults are a 10–450 MHz detector window with an 800–1600 MHz oscillator window. A slower device class is covered by setting 10–300 MHz and 600–1200 MHz.

The search is sequential and uses one shared serial divider. It first walks the integer settings. If none of them gives an exact hit, it repeats the walk with M, DOUT and the oscillator limits counted in eighths. M and DOUT are always reported in eighths. A request is offered with `req_valid` while `req_ready` is high. The engine accepts one request at a time and never stalls the caller. The answer appears with a single-cycle `res_valid` pulse, with no back-pressure on the result side. The result fields then hold still until the next answer. All internal arithmetic is `DW` bits wide, and `DW` must hold fin*M in eighths.

Top module: `clkgen_search`

## Requirements
- R1: `req_ready` is high only while the engine is idle; a request is taken on a clock edge with `req_valid` and `req_ready` both high, and `req_valid` while `req_ready` is low is ignored (the result returned is that of the request taken).
- R2: Every taken request produces exactly one `res_valid` pulse one cycle wide; `res_d`, `res_m8` and `res_dout8` change only in a cycle where `res_valid` is high and are 0 after reset.
- R3: A request with fin or fout equal to 0 answers with all three result fields 0, with `res_valid` two cycles after the accepting edge.
- R4: D is searched from max(ceil(fin/PFD_MAX), 1) up to min(floor(fin/PFD_MIN), D_LIMIT); when no candidate exists (for example fin below PFD_MIN) all result fields are 0 and `res_valid` still pulses.
- R5: In a pass with scale s (1 for integer, 8 for eighths), M runs from max(ceil(s*VCO_MIN/fin)*Dmin, 1) up to min(floor(s*VCO_MAX*Dmax/fin), s*M_LIMIT), in ascending order; for each M, D runs in ascending order from max(Dmin, ceil(fin*M/(s*VCO_MAX))) to min(Dmax, floor(fin*M/(s*VCO_MIN))).
- R6: For each candidate, fvco = floor(fin*M/D), DOUT = floor((fvco + floor(fout/2))/fout) clamped to 1..s*DOUT_LIMIT, and the achieved frequency is floor(fvco/DOUT).
- R7: A candidate becomes the best only when its absolute frequency error is strictly below that of the current best, so on a tie the earlier candidate in search order is kept.
- R8: A candidate with zero error ends the search at once; if it came from the integer pass, the eighths pass is skipped and the fields report M*8 and DOUT*8.
- R9: If the integer pass ends without an exact hit, the eighths pass runs with the best carried over, and a setting it finds is reported with M and DOUT as counted (in eighths).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| fin_khz | input | FW | Input frequency in kHz |
| fout_khz | input | FW | Target output frequency in kHz |
| res_valid | output | 1 | One-cycle result pulse |
| res_d | output | $clog2(D_LIMIT+1) | Chosen pre-divider, 0 if none |
| res_m8 | output | $clog2(8*M_LIMIT+1) | Chosen multiplier in eighths, 0 if none |
| res_dout8 | output | $clog2(8*DOUT_LIMIT+1) | Chosen output divider in eighths, 0 if none |

## Verification
The bench builds the engine with 8-bit frequency inputs and a 14-bit datapath. The limits are shrunk to a 10–40 kHz detector window and an 80–160 kHz oscillator window, with the default D, M and DOUT caps. At that scale a complete two-pass search over every M and D takes only thousands of cycles. The bench can then run full misses, integer hits, hits in the eighths pass, empty searches below the detector floor and zero inputs. Each result is compared against an arithmetic model of the search written in the bench.

// File: rtl/clkgen_search_pkg.sv
package clkgen_search_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DMIN, ST_DMAX, ST_MMIN, ST_MMAX, ST_MCHK, ST_DLO,
    ST_DHI, ST_DCHK, ST_FVCO, ST_DOUT, ST_FREQ, ST_PASS, ST_FIN
  } search_state_t;
endpackage

// File: rtl/clks_divider.sv
module clks_divider #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, r_r, den_r, num_r;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [W:0]    shifted, diff;

  assign shifted = {r_r, q_r[W-1]};
  assign diff    = shifted - {1'b0, den_r};
  assign quo     = q_r;
  assign rem     = r_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0; r_r <= '0; den_r <= '0; num_r <= '0;
      cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r <= num; r_r <= '0; den_r <= den; num_r <= num;
        cnt <= CW'(W); busy <= 1'b1;
      end else if (busy) begin
        if (!diff[W]) begin
          r_r <= diff[W-1:0];
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= shifted[W-1:0];
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6
  div_exact_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (({{W{1'b0}}, q_r} * {{W{1'b0}}, den_r}) + {{W{1'b0}}, r_r}
              == {{W{1'b0}}, num_r}) && (r_r < den_r));
endmodule

// File: rtl/clks_best_track.sv
module clks_best_track #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cand_valid,
  input  logic         frac,
  input  logic [W-1:0] cand_f,
  input  logic [W-1:0] target,
  input  logic [W-1:0] cand_d,
  input  logic [W-1:0] cand_m,
  input  logic [W-1:0] cand_dout,
  output logic         have,
  output logic         exact,
  output logic [W-1:0] best_d,
  output logic [W-1:0] best_m8,
  output logic [W-1:0] best_dout8
);
  logic [W-1:0] err, best_err;
  logic         take;

  assign err   = (cand_f >= target) ? cand_f - target : target - cand_f;
  assign take  = cand_valid && (!have || err < best_err);
  assign exact = cand_valid && (err == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      have <= 1'b0; best_err <= '0;
      best_d <= '0; best_m8 <= '0; best_dout8 <= '0;
    end else if (take) begin
      have       <= 1'b1;
      best_err   <= err;
      best_d     <= cand_d;
      best_m8    <= frac ? cand_m : cand_m << 3;
      best_dout8 <= frac ? cand_dout : cand_dout << 3;
    end
  end

  // R7
  err_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    (have && $past(have)) |-> best_err <= $past(best_err));
endmodule

// File: rtl/clkgen_search.sv
module clkgen_search
  import clkgen_search_pkg::*;
#(
  parameter int FW          = 32,
  parameter int DW          = 48,
  parameter int PFD_MIN_KHZ = 10000,
  parameter int PFD_MAX_KHZ = 450000,
  parameter int VCO_MIN_KHZ = 800000,
  parameter int VCO_MAX_KHZ = 1600000,
  parameter int D_LIMIT     = 80,
  parameter int M_LIMIT     = 64,
  parameter int DOUT_LIMIT  = 128,
  localparam int DOW  = $clog2(D_LIMIT + 1),
  localparam int MOW  = $clog2(8 * M_LIMIT + 1),
  localparam int DOTW = $clog2(8 * DOUT_LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [FW-1:0]   fin_khz,
  input  logic [FW-1:0]   fout_khz,
  output logic            res_valid,
  output logic [DOW-1:0]  res_d,
  output logic [MOW-1:0]  res_m8,
  output logic [DOTW-1:0] res_dout8
);
  localparam logic [DW-1:0] ONE    = DW'(1);
  localparam logic [DW-1:0] PFD_LO = DW'(PFD_MIN_KHZ);
  localparam logic [DW-1:0] PFD_HI = DW'(PFD_MAX_KHZ);
  localparam logic [DW-1:0] VMIN_I = DW'(VCO_MIN_KHZ);
  localparam logic [DW-1:0] VMIN_F = DW'(VCO_MIN_KHZ * 8);
  localparam logic [DW-1:0] VMAX_I = DW'(VCO_MAX_KHZ);
  localparam logic [DW-1:0] VMAX_F = DW'(VCO_MAX_KHZ * 8);
  localparam logic [DW-1:0] DCAP   = DW'(D_LIMIT);
  localparam logic [DW-1:0] MCAP_I = DW'(M_LIMIT);
  localparam logic [DW-1:0] MCAP_F = DW'(M_LIMIT * 8);
  localparam logic [DW-1:0] OCAP_I = DW'(DOUT_LIMIT);
  localparam logic [DW-1:0] OCAP_F = DW'(DOUT_LIMIT * 8);

  search_state_t st;
  logic [DW-1:0] fin_q, fout_q, dmin, dmax, mmax, m, d, dhi, fvco, dout;
  logic          frac, launched;
  logic [DW-1:0] vmin_s, vmax_s, mcap, ocap, fin_m, ceil_q, mmin_c;
  logic [DW-1:0] div_num, div_den, quo, rem;
  logic          is_div, div_start, div_done;
  logic          have, exact, tr_clr, cand_valid;
  logic [DW-1:0] best_d, best_m8, best_dout8;

  assign vmin_s    = frac ? VMIN_F : VMIN_I;
  assign vmax_s    = frac ? VMAX_F : VMAX_I;
  assign mcap      = frac ? MCAP_F : MCAP_I;
  assign ocap      = frac ? OCAP_F : OCAP_I;
  assign fin_m     = fin_q * m;
  assign ceil_q    = quo + {{(DW-1){1'b0}}, |rem};
  assign mmin_c    = ceil_q * dmin;
  assign req_ready = (st == ST_IDLE);
  assign div_start = is_div && !launched;
  assign tr_clr    = (st == ST_IDLE) && req_valid;
  assign cand_valid = (st == ST_FREQ) && div_done;

  always_comb begin
    is_div  = 1'b1;
    div_num = '0;
    div_den = ONE;
    case (st)
      ST_DMIN: begin div_num = fin_q;             div_den = PFD_HI; end
      ST_DMAX: begin div_num = fin_q;             div_den = PFD_LO; end
      ST_MMIN: begin div_num = vmin_s;            div_den = fin_q;  end
      ST_MMAX: begin div_num = vmax_s * dmax;     div_den = fin_q;  end
      ST_DLO:  begin div_num = fin_m;             div_den = vmax_s; end
      ST_DHI:  begin div_num = fin_m;             div_den = vmin_s; end
      ST_FVCO: begin div_num = fin_m;             div_den = d;      end
      ST_DOUT: begin div_num = fvco + (fout_q >> 1); div_den = fout_q; end
      ST_FREQ: begin div_num = fvco;              div_den = dout;   end
      default: is_div = 1'b0;
    endcase
  end

  clks_divider #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .done(div_done), .quo(quo), .rem(rem)
  );

  clks_best_track #(.W(DW)) u_best (
    .clk(clk), .rst(rst), .clr(tr_clr), .cand_valid(cand_valid), .frac(frac),
    .cand_f(quo), .target(fout_q), .cand_d(d), .cand_m(m), .cand_dout(dout),
    .have(have), .exact(exact), .best_d(best_d), .best_m8(best_m8),
    .best_dout8(best_dout8)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; fin_q <= '0; fout_q <= '0; frac <= 1'b0; launched <= 1'b0;
      dmin <= '0; dmax <= '0; mmax <= '0; m <= '0; d <= '0; dhi <= '0;
      fvco <= '0; dout <= '0;
      res_valid <= 1'b0; res_d <= '0; res_m8 <= '0; res_dout8 <= '0;
    end else begin
      res_valid <= 1'b0;
      if (div_start) launched <= 1'b1;
      if (div_done)  launched <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          fin_q  <= DW'(fin_khz);
          fout_q <= DW'(fout_khz);
          frac   <= 1'b0;
          st     <= (fin_khz == '0 || fout_khz == '0) ? ST_FIN : ST_DMIN;
        end
        ST_DMIN: if (div_done) begin
          dmin <= (ceil_q == '0) ? ONE : ceil_q;
          st   <= ST_DMAX;
        end
        ST_DMAX: if (div_done) begin
          dmax <= (quo > DCAP) ? DCAP : quo;
          st   <= ST_MMIN;
        end
        ST_MMIN: if (div_done) begin
          m  <= (mmin_c == '0) ? ONE : mmin_c;
          st <= ST_MMAX;
        end
        ST_MMAX: if (div_done) begin
          mmax <= (quo > mcap) ? mcap : quo;
          st   <= ST_MCHK;
        end
        ST_MCHK: st <= (m > mmax) ? ST_PASS : ST_DLO;
        ST_DLO: if (div_done) begin
          d  <= (ceil_q > dmin) ? ceil_q : dmin;
          st <= ST_DHI;
        end
        ST_DHI: if (div_done) begin
          dhi <= (quo < dmax) ? quo : dmax;
          st  <= ST_DCHK;
        end
        ST_DCHK: if (d > dhi) begin
          m  <= m + ONE;
          st <= ST_MCHK;
        end else begin
          st <= ST_FVCO;
        end
        ST_FVCO: if (div_done) begin
          fvco <= quo;
          st   <= ST_DOUT;
        end
        ST_DOUT: if (div_done) begin
          dout <= (quo == '0) ? ONE : ((quo > ocap) ? ocap : quo);
          st   <= ST_FREQ;
        end
        ST_FREQ: if (div_done) begin
          if (exact) st <= ST_FIN;
          else begin
            d  <= d + ONE;
            st <= ST_DCHK;
          end
        end
        ST_PASS: if (!frac) begin
          frac <= 1'b1;
          st   <= ST_MMIN;
        end else begin
          st <= ST_FIN;
        end
        ST_FIN: begin
          res_valid <= 1'b1;
          res_d     <= have ? DOW'(best_d) : '0;
          res_m8    <= have ? MOW'(best_m8) : '0;
          res_dout8 <= have ? DOTW'(best_dout8) : '0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> $stable(fin_q) && $stable(fout_q));
  // R2
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R2
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_d) && $stable(res_m8) && $stable(res_dout8));
  // R3
  zero_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (fin_khz == '0 || fout_khz == '0)) |=> ##1
    (res_valid && res_d == '0 && res_m8 == '0 && res_dout8 == '0));
  // R4
  d_bound_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_d <= DOW'(D_LIMIT));
  // R6
  dout_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_d != '0) |-> (res_dout8 != '0 && res_dout8 <= DOTW'(8 * DOUT_LIMIT)));
endmodule

// File: tb/clkgen_search_bench.sv
`timescale 1ns/1ps
module clkgen_search_bench;
  localparam int FW = 8, DW = 14;
  localparam int PMIN = 10, PMAX = 40, VMIN = 80, VMAX = 160;
  localparam int DLIM = 80, MLIM = 64, OLIM = 128;
  localparam int DOW = $clog2(DLIM + 1), MOW = $clog2(8 * MLIM + 1), DOTW = $clog2(8 * OLIM + 1);

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0, req_ready, res_valid;
  logic [FW-1:0] fin_khz = '0, fout_khz = '0;
  logic [DOW-1:0] res_d;
  logic [MOW-1:0] res_m8;
  logic [DOTW-1:0] res_dout8;
  int n_checks = 0, n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  clkgen_search #(.FW(FW), .DW(DW), .PFD_MIN_KHZ(PMIN), .PFD_MAX_KHZ(PMAX),
    .VCO_MIN_KHZ(VMIN), .VCO_MAX_KHZ(VMAX), .D_LIMIT(DLIM), .M_LIMIT(MLIM),
    .DOUT_LIMIT(OLIM)) u_clkgen_search (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .fin_khz(fin_khz), .fout_khz(fout_khz), .res_valid(res_valid),
    .res_d(res_d), .res_m8(res_m8), .res_dout8(res_dout8));

  function automatic void ref_search(input longint fi, input longint fo,
      output longint rd, output longint rm, output longint ro);
    longint dmin, dmax, mmin, mmax, dlo, dhi, vmn, vmx, fv, dv, f, e, be;
    bit have;
    rd = 0; rm = 0; ro = 0; have = 0; be = 0;
    if (fi == 0 || fo == 0) return;
    dmin = (fi + PMAX - 1) / PMAX; if (dmin < 1) dmin = 1;
    dmax = fi / PMIN; if (dmax > DLIM) dmax = DLIM;
    for (int s = 0; s <= 3; s += 3) begin
      vmn = VMIN << s; vmx = VMAX << s;
      mmin = ((vmn + fi - 1) / fi) * dmin; if (mmin < 1) mmin = 1;
      mmax = vmx * dmax / fi; if (mmax > (MLIM << s)) mmax = MLIM << s;
      for (longint m = mmin; m <= mmax; m++) begin
        dlo = (fi * m + vmx - 1) / vmx; if (dlo < dmin) dlo = dmin;
        dhi = fi * m / vmn; if (dhi > dmax) dhi = dmax;
        for (longint d = dlo; d <= dhi; d++) begin
          fv = fi * m / d;
          dv = (fv + fo / 2) / fo;
          if (dv < 1) dv = 1;
          if (dv > (OLIM << s)) dv = OLIM << s;
          f = fv / dv;
          e = (f > fo) ? f - fo : fo - f;
          if (!have || e < be) begin
            have = 1; be = e; rd = d;
            rm = (s == 0) ? m * 8 : m;
            ro = (s == 0) ? dv * 8 : dv;
            if (e == 0) return;
          end
        end
      end
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  task automatic wait_result(output int cyc);
    cyc = 0;
    while (!res_valid && cyc < 60000) begin @(negedge clk); cyc++; end
  endtask

  task automatic check_result(input int fi, input int fo, input string tag);
    longint ed, em, eo;
    logic [DOW-1:0] hd; logic [MOW-1:0] hm; logic [DOTW-1:0] ho;
    ref_search(fi, fo, ed, em, eo);
    chk(res_valid, "R2", "res_valid seen", res_valid, 1);
    chk(res_d == ed, tag, $sformatf("D fin=%0d fout=%0d", fi, fo), res_d, ed);
    chk(res_m8 == em, tag, $sformatf("M8 fin=%0d fout=%0d", fi, fo), res_m8, em);
    chk(res_dout8 == eo, tag, $sformatf("DOUT8 fin=%0d fout=%0d", fi, fo), res_dout8, eo);
    hd = res_d; hm = res_m8; ho = res_dout8;
    @(negedge clk);
    chk(!res_valid, "R2", "pulse width", res_valid, 0);
    repeat (3) @(negedge clk);
    chk(res_d == hd && res_m8 == hm && res_dout8 == ho, "R2", "hold after pulse",
        {res_d, res_m8, res_dout8}, {hd, hm, ho});
  endtask

  task automatic run_req(input int fi, input int fo, input string tag);
    int cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    fin_khz = FW'(fi); fout_khz = FW'(fo); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(cyc);
    check_result(fi, fo, tag);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cyc, rdy_seen;
    int f20[6] = '{10, 20, 40, 13, 27, 55};
    int f48[3] = '{24, 16, 35};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 R2 reset state
    chk(req_ready, "R1", "ready after reset", req_ready, 1);
    chk(!res_valid, "R2", "res_valid after reset", res_valid, 0);
    chk(res_d == 0 && res_m8 == 0 && res_dout8 == 0, "R2", "fields after reset",
        {res_d, res_m8, res_dout8}, 0);

    // R3 zero inputs, result two edges after acceptance
    fin_khz = 0; fout_khz = 50; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk(!res_valid, "R3", "no result one edge after", res_valid, 0);
    @(negedge clk);
    chk(res_valid, "R3", "result two edges after", res_valid, 1);
    check_result(0, 50, "R3");
    run_req(50, 0, "R3");

    // R4 fin below detector floor: empty search
    run_req(5, 10, "R4");

    // R1 requests while busy are ignored
    @(negedge clk);
    fin_khz = 50; fout_khz = 50; req_valid = 1'b1;
    @(negedge clk);
    fin_khz = 7; fout_khz = 3;
    rdy_seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (req_ready) rdy_seen++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rdy_seen == 0, "R1", "ready while busy", rdy_seen, 0);
    wait_result(cyc);
    check_result(50, 50, "R1 R8");
    chk(res_m8 % 8 == 0 && res_dout8 % 8 == 0, "R8", "integer hit in eighths",
        res_m8 % 8, 0);

    // R5 R6 R7 R8 R9 sweeps
    for (int i = 0; i < 6; i++) run_req(20, f20[i], "R5 R6 R7 R8 R9");
    for (int i = 0; i < 3; i++) run_req(48, f48[i], "R5 R6 R7 R9");
    run_req(63, 21, "R4 R5 R6");
    run_req(35, 1, "R6 R7");
    summary();
  end
endmodule